// File: doc/BRIEF.md
# TCP/UDP Header Exception Checker

This block watches the layer-4 portion of a received IP packet, one byte per valid beat, and gives a single 4-bit exception code for each segment. The byte stream begins at the first byte of the TCP or UDP header. A start strobe marks that first byte and a last strobe marks the final byte. On the start beat the block also samples three sideband values: whether the segment is TCP or UDP, the layer-4 length derived from the IP header, and a 16-bit partial sum of the pseudo-header formed upstream.

While the bytes stream past, the block accumulates a ones-complement checksum, counts the bytes, and keeps the port numbers, the UDP length and checksum fields, and the TCP flag bits. One clock after the last byte it raises a one-cycle done pulse. The verdict code is valid in that cycle and held at zero in every other cycle.

When several problems are present, a fixed priority picks one code. A short segment overrides everything else. Next come the checksum, length and port checks. The forbidden TCP flag patterns are looked at only when all of those are clean.

Top module: `l4_exc_chk`

## Requirements
- R1: A segment starts on a beat with `s_valid` and `s_sos` high and ends on a beat with `s_valid` and `s_last` high (the same beat may do both). `o_done` is high for exactly the one cycle after each accepted last beat, and in that cycle `o_code` carries the verdict. In every other cycle, including reset, `o_done` and `o_code` are 0. Sideband inputs are sampled on the start beat only.
- R2: Code 1 is reported when the segment holds fewer than 20 bytes for TCP or fewer than 8 bytes for UDP. It overrides every other code.
- R3: Code 2 is reported when the checksum fails. The checksum is formed as follows: bytes pair into 16-bit words, with the byte at even offset as the high half. An odd final byte is padded with a zero low half. All words and the pseudo-header sum are added with end-around carry. The segment passes only if the result is 0xFFFF.
- R4: For UDP, a checksum field of zero (offsets 6 and 7) disables the checksum check.
- R5: Code 3 is reported when the received byte count differs from `s_l4_len`. For UDP it is also reported when the length field at offsets 4 and 5 (big-endian) differs from `s_l4_len`.
- R6: Code 4 is reported when the source port (offsets 0 and 1) or the destination port (offsets 2 and 3) is zero.
- R7: Among codes 1 to 4 the lowest applicable code is reported. Flag codes are considered only when codes 1 to 4 are all clear, and only for TCP. A clean segment gives code 0.
- R8: TCP flags come from the byte at offset 13, and only its low six bits are considered: bit0 FIN, bit1 SYN, bit2 RST, bit5 URG. Code 8 is reported when these six bits equal 000001 (FIN only). Code 9 is reported when all six are zero. Bits 6 and 7 are ignored.
- R9: Code 10 is FIN and RST both set, code 11 is SYN and URG both set, code 12 is SYN and RST both set, and code 13 is SYN and FIN both set. Other bits may take any value. The patterns are tested in ascending code order, and the first match is reported.
- R10: Beats with `s_valid` low are ignored, so idle gaps inside a segment do not change the verdict. A new segment may start on the beat right after a last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Byte beat valid |
| s_sos | input | 1 | First byte of a segment |
| s_last | input | 1 | Final byte of a segment |
| s_byte | input | 8 | Segment byte |
| s_is_tcp | input | 1 | 1 = TCP, 0 = UDP (sampled on start beat) |
| s_l4_len | input | LEN_W | Layer-4 length from the IP header (sampled on start beat) |
| s_psum | input | 16 | Pseudo-header partial sum (sampled on start beat) |
| o_done | output | 1 | One-cycle verdict strobe |
| o_code | output | 4 | Exception code, valid with `o_done` |

## Verification
The assertions assume that each segment is framed correctly: every accepted last beat belongs to a segment that was opened by a start beat. They also assume that the byte count stays below the counter's saturation value, so that the count increments by one on every accepted beat. The stimulus keeps within these assumptions. Each segment is built from a header template of legal length, sized well below the limit, and every segment opens with a start beat. Idle gaps are placed only between beats. The bench never leaves a last beat without a segment around it.

// File: rtl/l4x_pkg.sv
package l4x_pkg;

  typedef enum logic [3:0] {
    EXC_NONE     = 4'd0,
    EXC_SHORT    = 4'd1,
    EXC_CSUM     = 4'd2,
    EXC_LEN      = 4'd3,
    EXC_PORT     = 4'd4,
    EXC_FIN_ONLY = 4'd8,
    EXC_NO_FLAGS = 4'd9,
    EXC_FIN_RST  = 4'd10,
    EXC_SYN_URG  = 4'd11,
    EXC_SYN_RST  = 4'd12,
    EXC_SYN_FIN  = 4'd13
  } exc_code_e;

  localparam int unsigned TCP_MIN_BYTES = 20;
  localparam int unsigned UDP_MIN_BYTES = 8;
  localparam int unsigned FLAG_BYTE_OFS = 13;
  localparam int unsigned FLG_FIN = 0;
  localparam int unsigned FLG_SYN = 1;
  localparam int unsigned FLG_RST = 2;
  localparam int unsigned FLG_URG = 5;
  localparam int unsigned FLAG_W  = 6;

  typedef struct packed {
    logic [15:0]       sport;
    logic [15:0]       dport;
    logic [15:0]       ulen;
    logic [15:0]       uck;
    logic [FLAG_W-1:0] flags;
  } l4_fields_t;

  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

endpackage

// File: rtl/l4x_csum_acc.sv
module l4x_csum_acc
  import l4x_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        first,
  input  logic [7:0]  data,
  input  logic [15:0] base,
  output logic [15:0] sum_fin_nxt
);

  logic [15:0] sum_q, sum_n;
  logic [7:0]  hi_q, hi_n;
  logic        half_q, half_n;
  logic [15:0] run_sum;
  logic        even_pos;

  always_comb begin
    run_sum  = first ? base : sum_q;
    even_pos = first | ~half_q;
    sum_n    = sum_q;
    hi_n     = hi_q;
    half_n   = half_q;
    if (beat) begin
      if (even_pos) begin
        hi_n   = data;
        half_n = 1'b1;
        sum_n  = run_sum;
      end else begin
        sum_n  = oc_add(run_sum, {hi_q, data});
        half_n = 1'b0;
      end
    end
    sum_fin_nxt = half_n ? oc_add(sum_n, {hi_n, 8'h00}) : sum_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      hi_q   <= '0;
      half_q <= 1'b0;
    end else if (beat) begin
      sum_q  <= sum_n;
      hi_q   <= hi_n;
      half_q <= half_n;
    end
  end

  // R3: the first byte of a segment always opens a word
  a_r3_first_opens_word: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first) |=> half_q);
  // R3: later bytes alternate between high and low halves
  a_r3_halves_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !first) |=> (half_q != $past(half_q)));

endmodule

// File: rtl/l4x_hdr_capture.sv
module l4x_hdr_capture
  import l4x_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [LEN_W-1:0] cnt_nxt,
  output l4_fields_t       fields_nxt
);

  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] cnt_q, idx;
  l4_fields_t       fld_q;

  always_comb begin
    idx        = first ? '0 : cnt_q;
    cnt_nxt    = cnt_q;
    fields_nxt = fld_q;
    if (beat) begin
      cnt_nxt = (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
      case (32'(idx))
        0:  fields_nxt.sport[15:8] = data;
        1:  fields_nxt.sport[7:0]  = data;
        2:  fields_nxt.dport[15:8] = data;
        3:  fields_nxt.dport[7:0]  = data;
        4:  fields_nxt.ulen[15:8]  = data;
        5:  fields_nxt.ulen[7:0]   = data;
        6:  fields_nxt.uck[15:8]   = data;
        7:  fields_nxt.uck[7:0]    = data;
        FLAG_BYTE_OFS: fields_nxt.flags = data[FLAG_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fld_q <= '0;
    end else if (beat) begin
      cnt_q <= cnt_nxt;
      fld_q <= fields_nxt;
    end
  end

  // R10: each accepted non-start beat advances the count by one
  a_r10_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !first && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R10: idle cycles leave the count untouched
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(cnt_q));

endmodule

// File: rtl/l4x_verdict.sv
module l4x_verdict
  import l4x_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             is_tcp,
  input  logic [LEN_W-1:0] rx_cnt,
  input  logic [LEN_W-1:0] ip_len,
  input  l4_fields_t       fld,
  input  logic [15:0]      csum,
  output exc_code_e        code
);

  logic              short_seg, ck_skip, ck_bad, len_bad, port_bad;
  logic [FLAG_W-1:0] f;

  always_comb begin
    f         = fld.flags;
    short_seg = 32'(rx_cnt) < (is_tcp ? TCP_MIN_BYTES : UDP_MIN_BYTES);
    ck_skip   = !is_tcp && (fld.uck == 16'h0000);
    ck_bad    = !ck_skip && (csum != 16'hFFFF);
    len_bad   = (32'(rx_cnt) != 32'(ip_len)) ||
                (!is_tcp && (32'(fld.ulen) != 32'(ip_len)));
    port_bad  = (fld.sport == 16'h0000) || (fld.dport == 16'h0000);

    if (short_seg)     code = EXC_SHORT;
    else if (ck_bad)   code = EXC_CSUM;
    else if (len_bad)  code = EXC_LEN;
    else if (port_bad) code = EXC_PORT;
    else if (!is_tcp)  code = EXC_NONE;
    else if (f == FLAG_W'(1) << FLG_FIN)   code = EXC_FIN_ONLY;
    else if (f == '0)                       code = EXC_NO_FLAGS;
    else if (f[FLG_FIN] && f[FLG_RST])      code = EXC_FIN_RST;
    else if (f[FLG_SYN] && f[FLG_URG])      code = EXC_SYN_URG;
    else if (f[FLG_SYN] && f[FLG_RST])      code = EXC_SYN_RST;
    else if (f[FLG_SYN] && f[FLG_FIN])      code = EXC_SYN_FIN;
    else                                    code = EXC_NONE;
  end

  // R8: flag codes never appear for UDP
  always_comb begin
    a_r8_flags_tcp_only: assert (is_tcp || code < EXC_FIN_ONLY);
  end

endmodule

// File: rtl/l4_exc_chk.sv
module l4_exc_chk
  import l4x_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             s_sos,
  input  logic             s_last,
  input  logic [7:0]       s_byte,
  input  logic             s_is_tcp,
  input  logic [LEN_W-1:0] s_l4_len,
  input  logic [15:0]      s_psum,
  output logic             o_done,
  output logic [3:0]       o_code
);

  logic             first, fin_beat;
  logic             tcp_q, tcp_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [LEN_W-1:0] cnt_nxt;
  l4_fields_t       fld_nxt;
  logic [15:0]      sum_nxt;
  exc_code_e        verdict;
  logic             done_q, done_n;
  logic [3:0]       code_q, code_n;

  assign first    = s_valid & s_sos;
  assign fin_beat = s_valid & s_last;

  l4x_csum_acc u_csum (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat        (s_valid),
    .first       (first),
    .data        (s_byte),
    .base        (s_psum),
    .sum_fin_nxt (sum_nxt)
  );

  l4x_hdr_capture #(.LEN_W(LEN_W)) u_hdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (s_valid),
    .first      (first),
    .data       (s_byte),
    .cnt_nxt    (cnt_nxt),
    .fields_nxt (fld_nxt)
  );

  always_comb begin
    tcp_n = first ? s_is_tcp : tcp_q;
    len_n = first ? s_l4_len : len_q;
  end

  l4x_verdict #(.LEN_W(LEN_W)) u_verdict (
    .is_tcp (tcp_n),
    .rx_cnt (cnt_nxt),
    .ip_len (len_n),
    .fld    (fld_nxt),
    .csum   (sum_nxt),
    .code   (verdict)
  );

  always_comb begin
    done_n = fin_beat;
    code_n = fin_beat ? verdict : EXC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcp_q <= 1'b0;
      len_q <= '0;
    end else if (first) begin
      tcp_q <= tcp_n;
      len_q <= len_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= done_n;
      code_q <= code_n;
    end
  end

  assign o_done = done_q;
  assign o_code = code_q;

  // R1: every accepted last beat yields a verdict strobe next cycle
  a_r1_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_last) |=> o_done);
  // R1: no strobe without a last beat one cycle earlier
  a_r1_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    o_done |-> $past(s_valid && s_last));
  // R1: code reads zero outside the strobe
  a_r1_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !o_done |-> (o_code == 4'd0));
  // R7: only defined codes are ever reported
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    o_done |-> (o_code <= 4'd4 || (o_code >= 4'd8 && o_code <= 4'd13)));

endmodule

// File: tb/l4_exc_chk_tb_top.sv
module l4_exc_chk_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_sos = 1'b0, s_last = 1'b0, s_is_tcp = 1'b0;
  logic [7:0]  s_byte = '0;
  logic [15:0] s_l4_len = '0, s_psum = '0;
  logic        o_done;
  logic [3:0]  o_code;

  int    n_checks = 0, n_errs = 0;
  int    pend_code = 0, exp_code = 0;
  string pend_tag = "R1", exp_tag = "R1";
  bit    exp_done = 1'b0, finished = 1'b0;
  int    cyc = 0;
  logic [7:0] seg[$];

  always #4 clk = ~clk;

  l4_exc_chk dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sos(s_sos), .s_last(s_last),
    .s_byte(s_byte), .s_is_tcp(s_is_tcp), .s_l4_len(s_l4_len), .s_psum(s_psum),
    .o_done(o_done), .o_code(o_code)
  );

  // reference: expected strobe/code one cycle after each accepted last beat
  always @(posedge clk) begin
    cyc      <= cyc + 1;
    exp_done <= rst_n && s_valid && s_last;
    exp_code <= (rst_n && s_valid && s_last) ? pend_code : 0;
    exp_tag  <= pend_tag;
  end

  always @(negedge clk) begin
    if (!finished) begin
      n_checks++;
      if (o_done !== exp_done) begin
        n_errs++;
        $display("FAIL R1 done actual=%0b expected=%0b at cycle %0d", o_done, exp_done, cyc);
      end
      n_checks++;
      if (o_code !== 4'(exp_code)) begin
        n_errs++;
        $display("FAIL %s code actual=%0d expected=%0d at cycle %0d", exp_tag, o_code, exp_code, cyc);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      n_errs++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  function automatic int fold(input int s);
    int r = s;
    while ((r >> 16) != 0) r = (r & 16'hFFFF) + (r >> 16);
    return r;
  endfunction

  function automatic int ref_sum(input int ps);
    int s = ps;
    for (int i = 0; i < seg.size(); i += 2) begin
      int w = int'(seg[i]) << 8;
      if (i + 1 < seg.size()) w = w | int'(seg[i+1]);
      s = fold(s + w);
    end
    return s;
  endfunction

  function automatic int ref_code(input bit tcp, input int iplen, input int ps);
    int n = seg.size();
    int sp, dp, ul, uc, fl;
    bit ckbad;
    if (n < (tcp ? 20 : 8)) return 1;
    sp = (int'(seg[0]) << 8) | int'(seg[1]);
    dp = (int'(seg[2]) << 8) | int'(seg[3]);
    ul = (int'(seg[4]) << 8) | int'(seg[5]);
    uc = (int'(seg[6]) << 8) | int'(seg[7]);
    ckbad = (ref_sum(ps) != 16'hFFFF);
    if (!tcp && uc == 0) ckbad = 1'b0;
    if (ckbad) return 2;
    if (n != iplen || (!tcp && ul != iplen)) return 3;
    if (sp == 0 || dp == 0) return 4;
    if (!tcp) return 0;
    fl = int'(seg[13]) & 63;
    if (fl == 1) return 8;
    if (fl == 0) return 9;
    if ((fl & 5) == 5) return 10;
    if ((fl & 34) == 34) return 11;
    if ((fl & 6) == 6) return 12;
    if ((fl & 3) == 3) return 13;
    return 0;
  endfunction

  task automatic build(input bit tcp, input int sp, input int dp, input int flags,
                       input int pay, input int seed);
    int hl = tcp ? 20 : 8;
    seg.delete();
    for (int i = 0; i < hl + pay; i++) seg.push_back(8'((i * 37 + seed) & 255));
    seg[0] = 8'(sp >> 8); seg[1] = 8'(sp);
    seg[2] = 8'(dp >> 8); seg[3] = 8'(dp);
    if (tcp) begin
      seg[12] = 8'h50;
      seg[13] = 8'(flags);
    end else begin
      seg[4] = 8'((hl + pay) >> 8); seg[5] = 8'(hl + pay);
    end
  endtask

  task automatic fix_ck(input bit tcp, input int ps);
    int off = tcp ? 16 : 6;
    int c;
    seg[off] = 8'h00; seg[off+1] = 8'h00;
    c = (~ref_sum(ps)) & 16'hFFFF;
    seg[off] = 8'(c >> 8); seg[off+1] = 8'(c);
  endtask

  task automatic send(input bit tcp, input int iplen, input int ps, input int gap, input string tag);
    for (int i = 0; i < seg.size(); i++) begin
      @(negedge clk);
      if (i == seg.size() - 1) begin
        pend_code = ref_code(tcp, iplen, ps);
        pend_tag  = tag;
      end
      s_valid  = 1'b1;
      s_sos    = (i == 0);
      s_last   = (i == seg.size() - 1);
      s_byte   = seg[i];
      s_is_tcp = (i == 0) ? tcp : ~tcp;
      s_l4_len = (i == 0) ? 16'(iplen) : 16'hDEAD;
      s_psum   = (i == 0) ? 16'(ps) : 16'hBEEF;
      if (gap > 0 && i != seg.size() - 1 && (i % gap) == 0) begin
        @(negedge clk);
        s_valid = 1'b0; s_sos = 1'b1; s_last = 1'b1; s_byte = 8'hFF;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b0; s_sos = 1'b0; s_last = 1'b0;
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;            // R1: reset state compared every cycle above
    idle(2);

    // R7: clean TCP, odd payload exercises R3 padding
    build(1, 1234, 80, 8'h18, 5, 3); fix_ck(1, 16'h1A2B);
    send(1, seg.size(), 16'h1A2B, 0, "R3"); idle(2);
    // clean UDP
    build(0, 53, 999, 0, 4, 7); fix_ck(0, 16'hF00D);
    send(0, seg.size(), 16'hF00D, 0, "R7"); idle(2);
    // R2: short TCP and short UDP
    build(1, 1, 2, 8'h01, 0, 5); void'(seg.pop_back()); void'(seg.pop_back());
    send(1, seg.size(), 0, 0, "R2"); idle(1);
    build(0, 0, 0, 0, 0, 9); void'(seg.pop_back());
    send(0, 3, 0, 0, "R2"); idle(1);
    // R3: corrupted checksum; with zero port too -> code 2 wins (R7)
    build(1, 10, 20, 8'h10, 6, 11); fix_ck(1, 16'h0100); seg[21] = seg[21] ^ 8'h40;
    send(1, seg.size(), 16'h0100, 0, "R3"); idle(1);
    build(1, 0, 20, 8'h01, 3, 12); fix_ck(1, 16'h0100); seg[18] = seg[18] ^ 8'h01;
    send(1, seg.size(), 16'h0100, 0, "R7"); idle(1);
    // R4: UDP with zero checksum field and arbitrary data
    build(0, 7, 8, 0, 9, 21); seg[6] = 8'h00; seg[7] = 8'h00;
    send(0, seg.size(), 16'h1234, 0, "R4"); idle(1);
    // R5: wrong IP length, wrong UDP length field
    build(1, 5, 6, 8'h10, 2, 30); fix_ck(1, 16'h2222);
    send(1, seg.size() + 1, 16'h2222, 0, "R5"); idle(1);
    build(0, 5, 6, 0, 2, 31); seg[5] = seg[5] ^ 8'h01; fix_ck(0, 16'h3333);
    send(0, seg.size(), 16'h3333, 0, "R5"); idle(1);
    // R7: length error beats bad flags
    build(1, 5, 6, 8'h00, 0, 32); fix_ck(1, 0);
    send(1, 19 + 2, 0, 0, "R7"); idle(1);
    // R6: zero source port, zero destination port
    build(1, 0, 443, 8'h00, 1, 40); fix_ck(1, 16'h4444);
    send(1, seg.size(), 16'h4444, 0, "R6"); idle(1);
    build(0, 443, 0, 0, 1, 41); fix_ck(0, 16'h4444);
    send(0, seg.size(), 16'h4444, 0, "R6"); idle(1);
    // R8: FIN only, no flags, FIN with bits 6/7 set
    build(1, 9, 9, 8'h01, 0, 50); fix_ck(1, 16'h55); send(1, 20, 16'h55, 0, "R8"); idle(1);
    build(1, 9, 9, 8'h00, 0, 51); fix_ck(1, 16'h55); send(1, 20, 16'h55, 0, "R8"); idle(1);
    build(1, 9, 9, 8'hC1, 0, 52); fix_ck(1, 16'h55); send(1, 20, 16'h55, 0, "R8"); idle(1);
    // R9: each forbidden pair plus an overlap resolved in ascending order
    build(1, 9, 9, 8'h05, 4, 60); fix_ck(1, 16'h66); send(1, 24, 16'h66, 0, "R9"); idle(1);
    build(1, 9, 9, 8'h22, 4, 61); fix_ck(1, 16'h66); send(1, 24, 16'h66, 0, "R9"); idle(1);
    build(1, 9, 9, 8'h06, 4, 62); fix_ck(1, 16'h66); send(1, 24, 16'h66, 0, "R9"); idle(1);
    build(1, 9, 9, 8'h03, 4, 63); fix_ck(1, 16'h66); send(1, 24, 16'h66, 0, "R9"); idle(1);
    build(1, 9, 9, 8'h27, 4, 64); fix_ck(1, 16'h66); send(1, 24, 16'h66, 0, "R9"); idle(1);
    build(1, 9, 9, 8'h12, 4, 65); fix_ck(1, 16'h66); send(1, 24, 16'h66, 0, "R9"); idle(1);
    // UDP byte 13 zero must not raise a flag code
    build(0, 9, 9, 0, 8, 66); seg[13] = 8'h00; fix_ck(0, 16'h77);
    send(0, 16, 16'h77, 0, "R7"); idle(1);
    // R10: gaps inside segments and back-to-back segments
    build(1, 100, 200, 8'h18, 7, 70); fix_ck(1, 16'hABCD);
    send(1, seg.size(), 16'hABCD, 2, "R10");
    build(0, 100, 200, 0, 3, 71); fix_ck(0, 16'h0F0F);
    send(0, seg.size(), 16'h0F0F, 3, "R10");
    build(1, 100, 200, 8'h01, 0, 72); fix_ck(1, 16'h0);
    send(1, seg.size(), 16'h0, 0, "R10");
    idle(4);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule